// File: doc/BRIEF.md
# Segment Access Rule Checker

This block judges one protection request at a time and says whether it may go ahead. A request is one of three things: a memory access to a segment (an instruction fetch, a data read or a data write at a given offset), an I/O instruction, or a privileged instruction. With the request come the running privilege level, the privilege level the selector asks for, and the target descriptor's privilege level, kind (code or data), read/write permission bit, limit and present bit. For I/O, the I/O privilege field is also supplied.

The verdict is registered. One cycle after a valid request it shows as a one-cycle grant pulse, or as a one-cycle fault pulse with a 3-bit cause. Finding descriptors, changing privilege through gates and taking the exception all happen outside the block. The surrounding pipeline supplies the already-fetched descriptor fields and acts on the verdict.

Top module: `access_rule_checker`

## Requirements
- R1: Privilege levels are 2-bit values, 0 most trusted and 3 least trusted. A request presented with `req_valid` high at a rising edge produces its verdict on `grant_o`, `fault_o` and `cause_o` right after that edge, for exactly one cycle. A cycle with `req_valid` low gives `grant_o` = 0 and `fault_o` = 0 one cycle later.
- R2: While `rst_n` is low at a rising edge, all outputs are 0 after that edge, whatever the request inputs are.
- R3: When `priv_i` = 1, the request is granted only if `cpl_i` = 0. Otherwise it faults with cause 6. The segment and I/O inputs have no effect on the verdict.
- R4: When `priv_i` = 0 and `io_i` = 1, the request is granted only if `cpl_i` <= `iopl_i`. Otherwise it faults with cause 5. The segment inputs have no effect on the verdict.
- R5: A segment request (`priv_i` = 0, `io_i` = 0) whose descriptor has `present_i` = 0 faults with cause 1.
- R6: Access kind `acc_i` is encoded 0 = fetch, 1 = read, 2 = write, 3 = read. A segment request faults with cause 2 in four cases: a fetch from a data segment (`code_i` = 0), a write to a code segment, a write to a data segment whose `rw_i` = 0, or a read of a code segment whose `rw_i` = 0.
- R7: A segment request faults with cause 3 when max(`cpl_i`, `rpl_i`) > `dpl_i`. A raised `rpl_i` can therefore cause a fault even when `cpl_i` alone would pass.
- R8: A segment request faults with cause 4 when `offset_i` > `limit_i`. An offset equal to the limit passes.
- R9: When several segment violations occur together, only the first one in this order is reported: not-present (1), type (2), privilege (3), limit (4).
- R10: `grant_o` and `fault_o` are never high together. When `grant_o` is high, `cause_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request is presented this cycle |
| priv_i | input | 1 | Request is a privileged instruction |
| io_i | input | 1 | Request is an I/O instruction |
| acc_i | input | 2 | Segment access kind (0 fetch, 1 read, 2 write, 3 read) |
| cpl_i | input | 2 | Running privilege level |
| rpl_i | input | 2 | Selector's requested privilege level |
| dpl_i | input | 2 | Descriptor privilege level |
| iopl_i | input | 2 | I/O privilege field |
| code_i | input | 1 | Descriptor is a code segment (0 = data) |
| rw_i | input | 1 | Code: readable; data: writable |
| present_i | input | 1 | Descriptor present bit |
| limit_i | input | OFS_W | Highest valid offset in the segment |
| offset_i | input | OFS_W | Offset of the access |
| grant_o | output | 1 | One-cycle grant pulse |
| fault_o | output | 1 | One-cycle fault pulse |
| cause_o | output | 3 | Fault cause (0 none, 1 absent, 2 type, 3 privilege, 4 limit, 5 I/O level, 6 privileged instruction) |

## Verification
The bench aims at the edges of each rule:
- **Offset at the limit and one past it.** A design that used `>=` would fault on the last valid byte.
- **A requested level above the running level.** A design that compared only the running level would grant accesses the selector should have blocked.
- **Two or more violations at once.** A wrong priority would report the wrong cause, for example limit instead of privilege.
- **Privileged and I/O requests with a hostile, absent descriptor on the inputs.** A design that let the segment checks leak in would report cause 1 where cause 6 or 5 belongs.

A behavioural model in the bench compares every cycle, including idle cycles. A verdict that lasts more than one cycle, or a pulse with no request behind it, is caught there.

// File: rtl/arc_pkg.sv
package arc_pkg;

    localparam int PL_W = 2;

    localparam logic [1:0] ACC_FETCH = 2'd0;
    localparam logic [1:0] ACC_READ  = 2'd1;
    localparam logic [1:0] ACC_WRITE = 2'd2;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_ABSENT = 3'd1,
        CAUSE_TYPE   = 3'd2,
        CAUSE_PRIV   = 3'd3,
        CAUSE_LIMIT  = 3'd4,
        CAUSE_IOPL   = 3'd5,
        CAUSE_INSTR  = 3'd6
    } cause_t;

    typedef struct packed {
        logic   grant;
        logic   fault;
        cause_t cause;
    } verdict_t;

endpackage

// File: rtl/arc_seg_eval.sv
module arc_seg_eval
    import arc_pkg::*;
#(
    parameter int OFS_W = 32
) (
    input  logic [PL_W-1:0]  cpl,
    input  logic [PL_W-1:0]  rpl,
    input  logic [PL_W-1:0]  dpl,
    input  logic [1:0]       acc,
    input  logic             is_code,
    input  logic             rw_ok,
    input  logic             present,
    input  logic [OFS_W-1:0] limit,
    input  logic [OFS_W-1:0] offset,
    output cause_t           seg_cause
);

    logic [PL_W-1:0] eff_pl;
    logic            type_bad;
    logic            pl_bad;
    logic            over_limit;

    always_comb begin
        eff_pl = (cpl > rpl) ? cpl : rpl;
        pl_bad = eff_pl > dpl;
        over_limit = offset > limit;

        unique case (acc)
            ACC_FETCH: type_bad = !is_code;
            ACC_WRITE: type_bad = is_code || !rw_ok;
            default:   type_bad = is_code && !rw_ok;
        endcase

        if (!present)        seg_cause = CAUSE_ABSENT;
        else if (type_bad)   seg_cause = CAUSE_TYPE;
        else if (pl_bad)     seg_cause = CAUSE_PRIV;
        else if (over_limit) seg_cause = CAUSE_LIMIT;
        else                 seg_cause = CAUSE_NONE;
    end

endmodule

// File: rtl/arc_instr_eval.sv
module arc_instr_eval
    import arc_pkg::*;
(
    input  logic [PL_W-1:0] cpl,
    input  logic [PL_W-1:0] iopl,
    input  logic            is_priv,
    output cause_t          instr_cause
);

    always_comb begin
        if (is_priv)
            instr_cause = (cpl == '0) ? CAUSE_NONE : CAUSE_INSTR;
        else
            instr_cause = (cpl <= iopl) ? CAUSE_NONE : CAUSE_IOPL;
    end

endmodule

// File: rtl/access_rule_checker.sv
module access_rule_checker
    import arc_pkg::*;
#(
    parameter int OFS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             priv_i,
    input  logic             io_i,
    input  logic [1:0]       acc_i,
    input  logic [1:0]       cpl_i,
    input  logic [1:0]       rpl_i,
    input  logic [1:0]       dpl_i,
    input  logic [1:0]       iopl_i,
    input  logic             code_i,
    input  logic             rw_i,
    input  logic             present_i,
    input  logic [OFS_W-1:0] limit_i,
    input  logic [OFS_W-1:0] offset_i,
    output logic             grant_o,
    output logic             fault_o,
    output logic [2:0]       cause_o
);

    cause_t   seg_cause;
    cause_t   instr_cause;
    verdict_t res_d, res_q;

    arc_seg_eval #(.OFS_W(OFS_W)) seg_i (
        .cpl       (cpl_i),
        .rpl       (rpl_i),
        .dpl       (dpl_i),
        .acc       (acc_i),
        .is_code   (code_i),
        .rw_ok     (rw_i),
        .present   (present_i),
        .limit     (limit_i),
        .offset    (offset_i),
        .seg_cause (seg_cause)
    );

    arc_instr_eval instr_i (
        .cpl         (cpl_i),
        .iopl        (iopl_i),
        .is_priv     (priv_i),
        .instr_cause (instr_cause)
    );

    always_comb begin
        res_d = '0;
        if (req_valid) begin
            res_d.cause = (priv_i || io_i) ? instr_cause : seg_cause;
            res_d.grant = (res_d.cause == CAUSE_NONE);
            res_d.fault = (res_d.cause != CAUSE_NONE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign grant_o = res_q.grant;
    assign fault_o = res_q.fault;
    assign cause_o = res_q.cause;

    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!grant_o && !fault_o));

    p_instr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && priv_i && cpl_i != 2'd0) |=> (fault_o && cause_o == 3'd6));

    p_iolevel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !priv_i && io_i && cpl_i > iopl_i) |=> (fault_o && cause_o == 3'd5));

    p_absent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !priv_i && !io_i && !present_i) |=> (fault_o && cause_o == 3'd1));

    p_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !priv_i && !io_i && offset_i > limit_i) |=> fault_o);

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> (!fault_o && cause_o == 3'd0));

endmodule

// File: tb/access_rule_checker_tb.sv
module access_rule_checker_tb_top;

    localparam int OFS_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             priv_i = 1'b0;
    logic             io_i = 1'b0;
    logic [1:0]       acc_i = '0;
    logic [1:0]       cpl_i = '0;
    logic [1:0]       rpl_i = '0;
    logic [1:0]       dpl_i = '0;
    logic [1:0]       iopl_i = '0;
    logic             code_i = 1'b0;
    logic             rw_i = 1'b0;
    logic             present_i = 1'b0;
    logic [OFS_W-1:0] limit_i = '0;
    logic [OFS_W-1:0] offset_i = '0;
    logic             grant_o;
    logic             fault_o;
    logic [2:0]       cause_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    access_rule_checker #(.OFS_W(OFS_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .priv_i(priv_i),
        .io_i(io_i), .acc_i(acc_i), .cpl_i(cpl_i), .rpl_i(rpl_i),
        .dpl_i(dpl_i), .iopl_i(iopl_i), .code_i(code_i), .rw_i(rw_i),
        .present_i(present_i), .limit_i(limit_i), .offset_i(offset_i),
        .grant_o(grant_o), .fault_o(fault_o), .cause_o(cause_o)
    );

    // Reference model: {grant, fault, cause}
    function automatic logic [4:0] ref_verdict();
        int c, eff;
        bit wr, fe;
        if (!req_valid) return 5'd0;
        c = 0;
        if (priv_i) begin
            if (cpl_i != 0) c = 6;
        end else if (io_i) begin
            if (int'(cpl_i) > int'(iopl_i)) c = 5;
        end else begin
            eff = (cpl_i > rpl_i) ? int'(cpl_i) : int'(rpl_i);
            fe = (acc_i == 2'd0);
            wr = (acc_i == 2'd2);
            if (!present_i) c = 1;
            else if ((fe && !code_i) || (wr && code_i) || (wr && !rw_i) ||
                     (!fe && !wr && code_i && !rw_i)) c = 2;
            else if (eff > int'(dpl_i)) c = 3;
            else if (offset_i > limit_i) c = 4;
        end
        return {c == 0, c != 0, 3'(c)};
    endfunction

    function automatic string tag_of(logic [4:0] v);
        case (v[2:0])
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R8";
            3'd5: return "R4";
            3'd6: return "R3";
            default: return v[4] ? "R10" : "R1";
        endcase
    endfunction

    task automatic compare(logic [4:0] exp, string tag);
        n_checks++;
        if ({grant_o, fault_o, cause_o} !== exp) begin
            n_fail++;
            $display("FAIL %s: got grant=%0b fault=%0b cause=%0d, expected grant=%0b fault=%0b cause=%0d",
                     tag, grant_o, fault_o, cause_o, exp[4], exp[3], exp[2:0]);
        end
    endtask

    // Inputs already applied at a negedge; verdict checked at the next negedge.
    task automatic step(string tag);
        logic [4:0] exp;
        exp = ref_verdict();
        @(negedge clk);
        compare(exp, (tag == "") ? tag_of(exp) : tag);
    endtask

    task automatic seg(logic [1:0] acc, logic [1:0] cpl, logic [1:0] rpl,
                       logic [1:0] dpl, logic code, logic rw, logic pres,
                       logic [OFS_W-1:0] lim, logic [OFS_W-1:0] ofs, string tag);
        req_valid = 1; priv_i = 0; io_i = 0; acc_i = acc; cpl_i = cpl;
        rpl_i = rpl; dpl_i = dpl; code_i = code; rw_i = rw; present_i = pres;
        limit_i = lim; offset_i = ofs;
        step(tag);
    endtask

    initial begin
        // R2: reset holds outputs low even with a request presented
        req_valid = 1; priv_i = 1; cpl_i = 2'd3;
        repeat (3) @(negedge clk);
        compare(5'd0, "R2");
        rst_n = 1;
        req_valid = 0; priv_i = 0;
        step("R1");

        // R7 / R8 / R6 directed
        seg(2'd1, 2'd0, 2'd0, 2'd0, 0, 1, 1, 32'h100, 32'h100, "R8");   // offset == limit passes
        seg(2'd1, 2'd0, 2'd0, 2'd0, 0, 1, 1, 32'h100, 32'h101, "R8");   // one past
        seg(2'd1, 2'd1, 2'd3, 2'd2, 0, 1, 1, 32'hFF, 32'h0, "R7");      // raised rpl blocks
        seg(2'd1, 2'd2, 2'd1, 2'd2, 0, 1, 1, 32'hFF, 32'h0, "R7");      // eff == dpl passes
        seg(2'd0, 2'd0, 2'd0, 2'd3, 0, 1, 1, 32'hFF, 32'h0, "R6");      // fetch from data
        seg(2'd2, 2'd0, 2'd0, 2'd3, 1, 1, 1, 32'hFF, 32'h0, "R6");      // write to code
        seg(2'd2, 2'd0, 2'd0, 2'd3, 0, 0, 1, 32'hFF, 32'h0, "R6");      // write read-only data
        seg(2'd1, 2'd0, 2'd0, 2'd3, 1, 0, 1, 32'hFF, 32'h0, "R6");      // read exec-only code
        seg(2'd3, 2'd0, 2'd0, 2'd3, 1, 1, 1, 32'hFF, 32'h0, "R6");      // kind 3 reads readable code
        seg(2'd0, 2'd3, 2'd3, 2'd3, 1, 0, 1, 32'hFF, 32'h10, "R10");    // fetch ok
        // R9 priority
        seg(2'd0, 2'd3, 2'd3, 2'd0, 0, 0, 0, 32'h0, 32'h5, "R9");       // all -> 1
        seg(2'd0, 2'd3, 2'd3, 2'd0, 0, 0, 1, 32'h0, 32'h5, "R9");       // type over priv/limit
        seg(2'd1, 2'd3, 2'd3, 2'd0, 0, 0, 1, 32'h0, 32'h5, "R9");       // priv over limit
        // R5
        seg(2'd1, 2'd0, 2'd0, 2'd3, 0, 1, 0, 32'hFF, 32'h0, "R5");
        // R3: privileged, hostile segment inputs ignored
        present_i = 0; offset_i = '1; limit_i = '0; req_valid = 1;
        priv_i = 1; io_i = 1; iopl_i = 2'd0; cpl_i = 2'd0; step("R3");
        cpl_i = 2'd1; step("R3");
        // R4: I/O
        priv_i = 0; io_i = 1; cpl_i = 2'd2; iopl_i = 2'd2; step("R4");
        cpl_i = 2'd3; step("R4");
        cpl_i = 2'd0; iopl_i = 2'd0; step("R4");
        // R1: pulse lasts one cycle
        req_valid = 0; step("R1");
        step("R1");

        // Random mix, compared every clock
        for (int i = 0; i < 4000; i++) begin
            req_valid = ($urandom_range(0, 7) != 0);
            priv_i = ($urandom_range(0, 7) == 0);
            io_i = ($urandom_range(0, 5) == 0);
            acc_i = 2'($urandom); cpl_i = 2'($urandom); rpl_i = 2'($urandom);
            dpl_i = 2'($urandom); iopl_i = 2'($urandom);
            code_i = 1'($urandom); rw_i = 1'($urandom);
            present_i = ($urandom_range(0, 9) != 0);
            limit_i = 32'($urandom_range(0, 64));
            offset_i = 32'($urandom_range(0, 64));
            step("");
        end

        // R2: synchronous reset mid-stream clears the next verdict
        req_valid = 1; priv_i = 1; cpl_i = 2'd2; rst_n = 0;
        @(negedge clk);
        compare(5'd0, "R2");
        rst_n = 1; req_valid = 0;
        step("R1");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule